// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM Datapath

This block is a small synchronous static memory with a 36-bit word made of four 9-bit byte lanes. Address, chip select and the write controls are sampled on the rising clock edge. A word is written in one of two ways. A byte-write enable together with a per-lane select mask stores only the selected lanes. A global write stores every lane and ignores the byte controls. Any other selected cycle is a read.

A static mode input selects the read latency. In flow-through mode the array output goes straight to the data port. In pipeline mode the data passes through an output register and appears one clock later. Deselect takes effect one stage earlier than read data: the port stops driving immediately after the edge that samples the deselect. This also applies when a pipelined read is still in the output register.

The three-state bus is modelled as a data port plus a drive-enable flag. Two asynchronous inputs gate the outputs without waiting for a clock: output enable, and a sleep input. Sleep also blocks writes and keeps the stored contents. A five-state output controller tracks what the last two sampled cycles were.

- `S_OFF`: the last sampled cycle was a deselect or a sleep cycle.
- `S_WR_IDLE`: a write was sampled and the cycle before it was not a read.
- `S_WR_TAIL`: a write was sampled right after a read.
- `S_RD_FIRST`: a read was sampled and the cycle before it was not a read.
- `S_RD_STREAM`: a read was sampled right after a read.

The sampled cycle type selects the next state:

- A deselect or sleep cycle goes to `S_OFF`.
- A write goes to `S_WR_TAIL` from either read state, and to `S_WR_IDLE` otherwise.
- A read goes to `S_RD_STREAM` from either read state, and to `S_RD_FIRST` otherwise.

Top module: `sync_sram_dp`

## Requirements
- R1: A cycle with `bw_en`=1, `glob_wr`=0 and a nonzero `lane_sel` stores only the lanes whose mask bit is set. Lane i is `wdata[9i+8:9i]`, and `lane_sel[i]` selects it. The other lanes keep their contents.
- R2: A cycle with `glob_wr`=1 stores all four lanes, whatever `bw_en` and `lane_sel` are.
- R3: A selected cycle with `glob_wr`=0 and either `bw_en`=0 or `lane_sel`=0 is a read and writes nothing.
- R4: With `pipe_mode`=0, a read sampled at edge k presents its data and drives the port from just after edge k until the next edge.
- R5: With `pipe_mode`=1, a read sampled at edge k presents its data just after edge k+1. This holds only when edge k+1 samples a read or a write. Just after edge k the port is not driven for this read.
- R6: An edge that samples `chip_sel`=0 turns the drive off just after that edge, in both modes. This includes the pipelined data of a read sampled one edge earlier.
- R7: `out_en`=0 forces `rdata_drive`=0 and `rdata`=0 at once, with no clock edge needed. `rvalid` is not affected by `out_en`.
- R8: `sleep`=1 forces `rdata_drive`=0, `rvalid`=0 and `rdata`=0 at once. An edge that samples `sleep`=1 writes nothing and counts as a deselect.
- R9: Stored words are kept through sleep and through reset.
- R10: A read of an address written on the previous edge returns the newly written word.
- R11: After reset, `rdata_drive`, `rvalid` and `rdata` are all 0.
- R12: With `pipe_mode`=1, a write sampled right after a read keeps driving that read's data in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_mode | input | 1 | Static latency select: 1 pipeline, 0 flow-through |
| chip_sel | input | 1 | Cycle select; 0 is a deselect |
| addr | input | 4 | Word address |
| bw_en | input | 1 | Byte-write enable |
| lane_sel | input | 4 | Per-lane write mask |
| glob_wr | input | 1 | Global write of all lanes |
| wdata | input | 36 | Write word |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power input |
| rdata | output | 36 | Read word; zero when not driven |
| rdata_drive | output | 1 | Output drive enable |
| rvalid | output | 1 | Read data timing valid (ignores `out_en`) |

## Verification
A wrong controller state shows up at the ports within one clock. For example:

- Confusing `S_RD_FIRST` with `S_RD_STREAM` makes the pipelined port drive a cycle too early or too late.
- Missing `S_WR_TAIL` drops the data of a read that is followed by a write.
- A deselect that is not honoured leaves `rdata_drive` high one cycle too long.

Lane-mask faults appear on the first read of the affected address, as a wrong 9-bit field. Asynchronous gating faults are caught between clock edges, right after `out_en` or `sleep` changes.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } cyc_op_e;

    typedef enum logic [2:0] {
        S_OFF       = 3'd0,
        S_WR_IDLE   = 3'd1,
        S_WR_TAIL   = 3'd2,
        S_RD_FIRST  = 3'd3,
        S_RD_STREAM = 3'd4
    } out_state_e;

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_dp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             chip_sel_i,
    input  logic             sleep_i,
    input  logic             bw_en_i,
    input  logic [LANES-1:0] lane_sel_i,
    input  logic             glob_wr_i,
    output cyc_op_e          op_o,
    output logic [LANES-1:0] wr_mask_o
);

    always_comb begin
        op_o      = OP_IDLE;
        wr_mask_o = '0;
        if (chip_sel_i && !sleep_i) begin
            if (glob_wr_i) begin
                op_o      = OP_WRITE;
                wr_mask_o = '1;
            end else if (bw_en_i && (|lane_sel_i)) begin
                op_o      = OP_WRITE;
                wr_mask_o = lane_sel_i;
            end else begin
                op_o = OP_READ;
            end
        end
    end

endmodule

// File: rtl/sram_out_fsm.sv
module sram_out_fsm
    import sram_dp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pipe_mode_i,
    input  cyc_op_e op_i,
    output logic    timing_rd_o
);

    out_state_e state_q, state_d;
    logic       rd_now;
    logic       ft_rd, pl_rd;

    assign rd_now = (state_q == S_RD_FIRST) || (state_q == S_RD_STREAM);

    always_comb begin
        state_d = S_OFF;
        unique case (op_i)
            OP_IDLE:  state_d = S_OFF;
            OP_WRITE: state_d = rd_now ? S_WR_TAIL   : S_WR_IDLE;
            OP_READ:  state_d = rd_now ? S_RD_STREAM : S_RD_FIRST;
            default:  state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ft_rd = 1'b0;
        pl_rd = 1'b0;
        unique case (state_q)
            S_OFF:       begin ft_rd = 1'b0; pl_rd = 1'b0; end
            S_WR_IDLE:   begin ft_rd = 1'b0; pl_rd = 1'b0; end
            S_WR_TAIL:   begin ft_rd = 1'b0; pl_rd = 1'b1; end
            S_RD_FIRST:  begin ft_rd = 1'b1; pl_rd = 1'b0; end
            S_RD_STREAM: begin ft_rd = 1'b1; pl_rd = 1'b1; end
            default:     begin ft_rd = 1'b0; pl_rd = 1'b0; end
        endcase
        timing_rd_o = pipe_mode_i ? pl_rd : ft_rd;
    end

    // R6: a sampled deselect ends the read timing right after its edge
    p_desel_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_IDLE) |=> !timing_rd_o);

    // R4: flow-through read is presented in the cycle after its edge
    p_flow_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode_i && op_i == OP_READ) |=> timing_rd_o);

    // R5: pipelined read is not presented in the cycle after its edge
    p_pipe_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode_i && op_i == OP_READ && !rd_now) |=> !timing_rd_o);

    // R12: a write right after a pipelined read keeps that read on the port
    p_pipe_tail_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode_i && op_i == OP_READ) ##1 (op_i == OP_WRITE) |=> timing_rd_o);

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [LANE_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [LANE_W-1:0] rdata_o
);

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pipe_mode_i,
    input  logic [W-1:0] flow_data_i,
    input  logic         timing_rd_i,
    input  logic         out_en_i,
    input  logic         sleep_i,
    output logic [W-1:0] rdata_o,
    output logic         drive_o,
    output logic         rvalid_o
);

    logic [W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= flow_data_i;
        end
    end

    assign rvalid_o = timing_rd_i && !sleep_i;
    assign drive_o  = rvalid_o && out_en_i;
    assign rdata_o  = drive_o ? (pipe_mode_i ? pipe_q : flow_data_i) : '0;

    // R7: output enable low blanks the port
    p_oe_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |-> (!drive_o && rdata_o == '0));

endmodule

// File: rtl/sync_sram_dp.sv
module sync_sram_dp
    import sram_dp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    localparam int W     = LANES * LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_mode,
    input  logic             chip_sel,
    input  logic [AW-1:0]    addr,
    input  logic             bw_en,
    input  logic [LANES-1:0] lane_sel,
    input  logic             glob_wr,
    input  logic [W-1:0]     wdata,
    input  logic             out_en,
    input  logic             sleep,
    output logic [W-1:0]     rdata,
    output logic             rdata_drive,
    output logic             rvalid
);

    cyc_op_e          op;
    logic [LANES-1:0] wr_mask;
    logic [AW-1:0]    cap_addr;
    logic [W-1:0]     flow_data;
    logic             timing_rd;

    sram_cmd_decode #(.LANES(LANES)) dec_i (
        .chip_sel_i (chip_sel),
        .sleep_i    (sleep),
        .bw_en_i    (bw_en),
        .lane_sel_i (lane_sel),
        .glob_wr_i  (glob_wr),
        .op_o       (op),
        .wr_mask_o  (wr_mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
        end else begin
            cap_addr <= addr;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_bank #(.LANE_W(LANE_W), .DEPTH(DEPTH)) bank_i (
            .clk     (clk),
            .we_i    (wr_mask[g]),
            .waddr_i (addr),
            .wdata_i (wdata[g*LANE_W +: LANE_W]),
            .raddr_i (cap_addr),
            .rdata_o (flow_data[g*LANE_W +: LANE_W])
        );
    end

    sram_out_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pipe_mode_i (pipe_mode),
        .op_i        (op),
        .timing_rd_o (timing_rd)
    );

    sram_out_stage #(.W(W)) out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pipe_mode_i (pipe_mode),
        .flow_data_i (flow_data),
        .timing_rd_i (timing_rd),
        .out_en_i    (out_en),
        .sleep_i     (sleep),
        .rdata_o     (rdata),
        .drive_o     (rdata_drive),
        .rvalid_o    (rvalid)
    );

    // R8: no lane is written on an edge that samples sleep
    p_sleep_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (wr_mask == '0));

    // R2: global write enables every lane regardless of byte controls
    p_glob_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && !sleep && glob_wr) |-> (wr_mask == '1));

    // R3: byte enable with an empty mask is not a write
    p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && !glob_wr && lane_sel == '0) |-> (wr_mask == '0));

endmodule

// File: tb/sync_sram_dp_tb_top.sv
module sync_sram_dp_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DEPTH = 16;
    localparam int W     = LANES * LW;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pipe_mode = 1'b0;
    logic             chip_sel = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             bw_en = 1'b0;
    logic [LANES-1:0] lane_sel = '0;
    logic             glob_wr = 1'b0;
    logic [W-1:0]     wdata = '0;
    logic             out_en = 1'b1;
    logic             sleep = 1'b0;
    logic [W-1:0]     rdata;
    logic             rdata_drive;
    logic             rvalid;

    int n_checks = 0;
    int n_fails  = 0;

    logic [W-1:0] model [DEPTH];
    logic         prev_rd, cur_rd, cur_desel;
    logic [W-1:0] prev_snap, cur_snap;

    always #2.5 clk = ~clk;

    sync_sram_dp dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .chip_sel(chip_sel),
        .addr(addr), .bw_en(bw_en), .lane_sel(lane_sel), .glob_wr(glob_wr),
        .wdata(wdata), .out_en(out_en), .sleep(sleep), .rdata(rdata),
        .rdata_drive(rdata_drive), .rvalid(rvalid)
    );

    function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw,
                                           logic [LANES-1:0] m);
        logic [W-1:0] r = old;
        for (int i = 0; i < LANES; i++)
            if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    task automatic check_now(string tag, logic e_drv, logic e_val, logic [W-1:0] e_dat);
        n_checks++;
        if (rdata_drive !== e_drv || rvalid !== e_val || rdata !== e_dat) begin
            n_fails++;
            $display("FAIL %s: actual drive=%0b valid=%0b data=%h expected drive=%0b valid=%0b data=%h",
                     tag, rdata_drive, rvalid, rdata, e_drv, e_val, e_dat);
        end
    endtask

    task automatic do_cycle(string tag, logic s, logic [AW-1:0] a, logic b,
                            logic [LANES-1:0] l, logic g, logic [W-1:0] d,
                            logic oe, logic slp);
        logic is_wr, is_rd, e_t;
        logic [W-1:0] v;
        chip_sel = s; addr = a; bw_en = b; lane_sel = l; glob_wr = g;
        wdata = d; out_en = oe; sleep = slp;
        @(posedge clk);
        is_wr = s && !slp && (g || (b && (|l)));
        is_rd = s && !slp && !is_wr;
        prev_rd = cur_rd; prev_snap = cur_snap;
        if (is_wr) model[a] = merge(model[a], d, g ? '1 : l);
        cur_rd = is_rd; cur_snap = model[a]; cur_desel = !(s && !slp);
        @(negedge clk);
        e_t = pipe_mode ? (prev_rd && !cur_desel) : cur_rd;
        v   = pipe_mode ? prev_snap : cur_snap;
        check_now(tag, e_t && !slp && oe, e_t && !slp, (e_t && !slp && oe) ? v : '0);
    endtask

    task automatic do_reset(logic pm);
        rst_n = 1'b0; chip_sel = 1'b0; sleep = 1'b0; out_en = 1'b1;
        bw_en = 1'b0; glob_wr = 1'b0; lane_sel = '0;
        pipe_mode = pm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prev_rd = 1'b0; cur_rd = 1'b0; cur_desel = 1'b1;
        prev_snap = '0; cur_snap = '0;
        #1 check_now("R11 reset", 1'b0, 1'b0, '0);
    endtask

    task automatic rand_run(int n);
        for (int i = 0; i < n; i++) begin
            int k;
            logic oe, slp;
            string tag;
            k   = $urandom_range(0, 9);
            oe  = ($urandom_range(0, 7) != 0);
            slp = ($urandom_range(0, 15) == 0);
            tag = slp ? "R8 random" : (!oe ? "R7 random" : (pipe_mode ? "R5 random" : "R4 random"));
            case (k)
                0, 1:    do_cycle(tag, 1'b0, AW'($urandom), 1'b0, '0, 1'b0, '0, oe, slp);
                5, 6:    do_cycle(tag, 1'b1, AW'($urandom), 1'b1,
                                  LANES'($urandom_range(1, 15)), 1'b0,
                                  {4'($urandom), 32'($urandom)}, oe, slp);
                7:       do_cycle(tag, 1'b1, AW'($urandom), 1'($urandom),
                                  LANES'($urandom), 1'b1,
                                  {4'($urandom), 32'($urandom)}, oe, slp);
                8:       do_cycle(tag, 1'b1, AW'($urandom), 1'b1, '0, 1'b0,
                                  {4'($urandom), 32'($urandom)}, oe, slp);
                default: do_cycle(tag, 1'b1, AW'($urandom), 1'b0,
                                  LANES'($urandom), 1'b0, '0, oe, slp);
            endcase
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL R11 watchdog: actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;

        // flow-through mode
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++)
            do_cycle("R2 fill", 1'b1, AW'(i), 1'b1, LANES'(i), 1'b1,
                     {4'(i), 32'hA5A5_0000 + 32'(i * 7)}, 1'b1, 1'b0);
        for (int i = 0; i < DEPTH; i++)
            do_cycle("R2 readback", 1'b1, AW'(i), 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R1 byte write", 1'b1, 4'd3, 1'b1, 4'b1010, 1'b0, 36'hF_FFFF_FFFF, 1'b1, 1'b0);
        do_cycle("R1 lanes kept", 1'b1, 4'd3, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R1 single lane", 1'b1, 4'd4, 1'b1, 4'b0001, 1'b0, 36'h0_0000_0000, 1'b1, 1'b0);
        do_cycle("R1 single readback", 1'b1, 4'd4, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R3 empty mask read", 1'b1, 4'd5, 1'b1, 4'b0000, 1'b0, 36'h1_2345_6789, 1'b1, 1'b0);
        do_cycle("R3 unchanged", 1'b1, 4'd5, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R10 write", 1'b1, 4'd7, 1'b0, '0, 1'b1, 36'h9_8765_4321, 1'b1, 1'b0);
        do_cycle("R10 read after write", 1'b1, 4'd7, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R4 read", 1'b1, 4'd2, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        out_en = 1'b0;
        #1 check_now("R7 async oe low", 1'b0, 1'b1, '0);
        out_en = 1'b1;
        #1 check_now("R7 async oe high", 1'b1, 1'b1, model[2]);
        sleep = 1'b1;
        #1 check_now("R8 async sleep", 1'b0, 1'b0, '0);
        do_cycle("R8 write blocked", 1'b1, 4'd2, 1'b1, 4'b1111, 1'b1, 36'h0_DEAD_BEEF, 1'b1, 1'b1);
        do_cycle("R9 after sleep", 1'b1, 4'd2, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R6 flow deselect", 1'b0, 4'd2, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);

        // pipeline mode, memory kept across reset
        do_reset(1'b1);
        do_cycle("R5 first read quiet", 1'b1, 4'd7, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R9 read after reset", 1'b1, 4'd8, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R6 pipe deselect cut", 1'b0, 4'd0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R5 read", 1'b1, 4'd9, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R12 write tail", 1'b1, 4'd9, 1'b0, '0, 1'b1, 36'h3_3333_3333, 1'b1, 1'b0);
        do_cycle("R12 after tail", 1'b1, 4'd9, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        do_cycle("R10 pipe new data", 1'b1, 4'd1, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
        rand_run(400);

        do_reset(1'b0);
        rand_run(400);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule